// File: doc/BRIEF.md
# Tag-Matched Token-Driven ALU Unit

This block lets a small integer ALU work under a token-distribution control scheme. A token generator broadcasts control tokens; each token names a target unit, an operation, the version tag the operands must carry, a destination port for the result and a flag that bumps the result tag. Tokens addressed to this unit are queued in arrival order. The operation at the queue head fires only when its operands, latched on two data ports, carry the tag the token expects. An operation that takes no operands fires as soon as it reaches the head.

The result leaves through a valid/ready output together with its tag and the destination port copied from the token. The tag equals the token tag, incremented by one modulo 2^TAG_W when the token's increment flag is set. Data whose tag does not match waits in its port until a matching token arrives or a newer strobe replaces it.

Top module: `tfu_core`

## Requirements
- R1: After reset `res_valid` is 0 and `tok_ready` is 1; no result appears until a token is accepted.
- R2: A token whose `tok_unit` differs from parameter `UNIT_ID` is taken off the bus but never executed and leaves operand ports untouched.
- R3: Operation codes on `tok_op`: 0 add, 1 subtract (A-B), 2 AND, 3 OR, 4 XOR, 5 shift A left by the low log2(DW) bits of B, 6 pass A, 7 emit zero; arithmetic wraps modulo 2^DW.
- R4: Codes 0 to 5 fire only when both ports hold data whose tag equals the token tag; code 6 needs only port A; a fired operation consumes the ports it used.
- R5: Port data with a non-matching tag is kept, not consumed, and is used later by a token carrying its tag; a new valid strobe on a port replaces its contents.
- R6: Code 7 needs no operands: with an idle output, its result is valid at the second rising edge after the token is accepted.
- R7: `res_tag` equals the token tag when `tok_inc` is 0 and the token tag plus one modulo 2^TAG_W when it is 1.
- R8: `res_dest` equals the token's `tok_dest`.
- R9: Up to DEPTH (4) tokens wait in a queue and execute strictly in arrival order; `tok_ready` is 0 while the queue is full and a token offered then is not taken.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data`, `res_tag` and `res_dest` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token present on the token bus |
| tok_ready | output | 1 | Token queue has room |
| tok_unit | input | UID_W | Target unit of the token |
| tok_op | input | 3 | Operation code |
| tok_tag | input | TAG_W | Tag the operands must carry |
| tok_dest | input | DEST_W | Destination port for the result |
| tok_inc | input | 1 | Increment the result tag |
| opa_valid | input | 1 | Strobe for operand A |
| opa_data | input | DW | Operand A value |
| opa_tag | input | TAG_W | Operand A tag |
| opb_valid | input | 1 | Strobe for operand B |
| opb_data | input | DW | Operand B value |
| opb_tag | input | TAG_W | Operand B tag |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Receiver takes the result |
| res_data | output | DW | Result value |
| res_tag | output | TAG_W | Result tag |
| res_dest | output | DEST_W | Destination port of the result |

## Verification
A vector table drives every operation code with operands whose tags match, mixing increment settings, a tag of 0xFF that must wrap to 0x00, and a subtract and add that wrap the data word; these separate the opcode decode, the tag arithmetic and the destination copy. Directed sequences then present operands with a wrong tag, a token for another unit and a pass operation with port B empty, which tell matching apart from mere arrival and show that unused data survives. A stalled output with a queue of zero-operand tokens shows the queue bound, strict ordering and the stability of held results.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_PASS = 3'd6,
    OP_ZERO = 3'd7
  } tfu_op_e;

  localparam int OP_W = 3;

  function automatic logic op_uses_a(tfu_op_e op);
    return op != OP_ZERO;
  endfunction

  function automatic logic op_uses_b(tfu_op_e op);
    return op <= OP_SHL;
  endfunction
endpackage

// File: rtl/tfu_tok_fifo.sv
module tfu_tok_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
endmodule

// File: rtl/tfu_opnd_port.sv
module tfu_opnd_port #(
  parameter int DW    = 32,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             consume,
  output logic             held,
  output logic [DW-1:0]    data,
  output logic [TAG_W-1:0] tag
);
  logic             held_d;
  logic [DW-1:0]    data_q;
  logic [TAG_W-1:0] tag_q;

  always_comb begin
    held_d = held;
    if (consume)  held_d = 1'b0;
    if (in_valid) held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      data_q <= '0;
      tag_q  <= '0;
    end else begin
      held <= held_d;
      if (in_valid) begin
        data_q <= in_data;
        tag_q  <= in_tag;
      end
    end
  end

  assign data = data_q;
  assign tag  = tag_q;
endmodule

// File: rtl/tfu_alu.sv
module tfu_alu
  import tfu_pkg::*;
#(
  parameter int DW = 32
) (
  input  tfu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam int SHW = $clog2(DW);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << b[SHW-1:0];
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tfu_core.sv
module tfu_core
  import tfu_pkg::*;
#(
  parameter int DW      = 32,
  parameter int TAG_W   = 8,
  parameter int UID_W   = 4,
  parameter int DEST_W  = 4,
  parameter int DEPTH   = 4,
  parameter int UNIT_ID = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [UID_W-1:0]  tok_unit,
  input  logic [2:0]        tok_op,
  input  logic [TAG_W-1:0]  tok_tag,
  input  logic [DEST_W-1:0] tok_dest,
  input  logic              tok_inc,
  input  logic              opa_valid,
  input  logic [DW-1:0]     opa_data,
  input  logic [TAG_W-1:0]  opa_tag,
  input  logic              opb_valid,
  input  logic [DW-1:0]     opb_data,
  input  logic [TAG_W-1:0]  opb_tag,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DW-1:0]     res_data,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DEST_W-1:0] res_dest
);
  localparam int TOK_W = OP_W + TAG_W + DEST_W + 1;
  localparam int CW    = $clog2(DEPTH+1);
  localparam int NPORT = 2;

  logic             q_push, q_pop, q_empty, q_full;
  logic [TOK_W-1:0] q_head;
  logic [CW-1:0]    q_count;

  tfu_op_e           h_op;
  logic [TAG_W-1:0]  h_tag;
  logic [DEST_W-1:0] h_dest;
  logic              h_inc;

  logic [NPORT-1:0]  p_in_v, p_consume, p_held, p_need, p_ok;
  logic [DW-1:0]     p_in_d  [NPORT];
  logic [TAG_W-1:0]  p_in_t  [NPORT];
  logic [DW-1:0]     p_data  [NPORT];
  logic [TAG_W-1:0]  p_tag   [NPORT];

  logic              out_free, fire;
  logic [DW-1:0]     alu_y;

  logic              rv_d;
  logic [DW-1:0]     rd_d;
  logic [TAG_W-1:0]  rt_d;
  logic [DEST_W-1:0] rdst_d;

  assign tok_ready = !q_full;
  assign q_push    = tok_valid && tok_ready && (tok_unit == UID_W'(UNIT_ID));

  tfu_tok_fifo #(.W(TOK_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   ({tok_op, tok_tag, tok_dest, tok_inc}),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full),
    .count (q_count)
  );

  assign h_op   = tfu_op_e'(q_head[TOK_W-1 -: OP_W]);
  assign h_tag  = q_head[DEST_W+1 +: TAG_W];
  assign h_dest = q_head[1 +: DEST_W];
  assign h_inc  = q_head[0];

  assign p_in_v = {opb_valid, opa_valid};
  assign p_in_d[0] = opa_data;
  assign p_in_d[1] = opb_data;
  assign p_in_t[0] = opa_tag;
  assign p_in_t[1] = opb_tag;
  assign p_need = {op_uses_b(h_op), op_uses_a(h_op)};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    tfu_opnd_port #(.DW(DW), .TAG_W(TAG_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (p_in_v[g]),
      .in_data  (p_in_d[g]),
      .in_tag   (p_in_t[g]),
      .consume  (p_consume[g]),
      .held     (p_held[g]),
      .data     (p_data[g]),
      .tag      (p_tag[g])
    );
    assign p_ok[g]      = !p_need[g] || (p_held[g] && (p_tag[g] == h_tag));
    assign p_consume[g] = fire && p_need[g];
  end

  assign out_free = !res_valid || res_ready;
  assign fire     = !q_empty && (&p_ok) && out_free;
  assign q_pop    = fire;

  tfu_alu #(.DW(DW)) u_alu (
    .op (h_op),
    .a  (p_data[0]),
    .b  (p_data[1]),
    .y  (alu_y)
  );

  always_comb begin
    rv_d   = res_valid;
    rd_d   = res_data;
    rt_d   = res_tag;
    rdst_d = res_dest;
    if (res_valid && res_ready) rv_d = 1'b0;
    if (fire) begin
      rv_d   = 1'b1;
      rd_d   = alu_y;
      rt_d   = h_tag + TAG_W'(h_inc);
      rdst_d = h_dest;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_tag   <= '0;
      res_dest  <= '0;
    end else begin
      res_valid <= rv_d;
      res_data  <= rd_d;
      res_tag   <= rt_d;
      res_dest  <= rdst_d;
    end
  end
endmodule

// File: rtl/tfu_core_chk.sv
module tfu_core_chk #(
  parameter int DW      = 32,
  parameter int TAG_W   = 8,
  parameter int UID_W   = 4,
  parameter int DEST_W  = 4,
  parameter int DEPTH   = 4,
  parameter int UNIT_ID = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [UID_W-1:0]  tok_unit,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DW-1:0]     res_data,
  input logic [TAG_W-1:0]  res_tag,
  input logic [DEST_W-1:0] res_dest,
  input logic              fire,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic [2:0]        h_op,
  input logic [TAG_W-1:0]  h_tag,
  input logic [DEST_W-1:0] h_dest,
  input logic              h_inc,
  input logic              pa_held,
  input logic [TAG_W-1:0]  pa_tag
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_tag) && $stable(res_dest)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH+1))'(DEPTH)); // R9

  AST_FIRE_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (h_op != 3'd7) |-> pa_held && (pa_tag == h_tag)); // R4

  AST_OUT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid && (res_tag == $past(h_tag + TAG_W'(h_inc)))); // R7

  AST_OUT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_dest == $past(h_dest)); // R8

  AST_FOREIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && (tok_unit != UID_W'(UNIT_ID)) |=> q_count <= $past(q_count)); // R2
endmodule

bind tfu_core tfu_core_chk #(
  .DW(DW), .TAG_W(TAG_W), .UID_W(UID_W), .DEST_W(DEST_W), .DEPTH(DEPTH), .UNIT_ID(UNIT_ID)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tok_valid (tok_valid),
  .tok_unit  (tok_unit),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_tag   (res_tag),
  .res_dest  (res_dest),
  .fire      (fire),
  .q_count   (q_count),
  .h_op      (q_head[TOK_W-1 -: 3]),
  .h_tag     (h_tag),
  .h_dest    (h_dest),
  .h_inc     (h_inc),
  .pa_held   (p_held[0]),
  .pa_tag    (p_tag[0])
);

// File: tb/tfu_core_tb.sv
module tfu_core_tb;
  localparam int DW = 32, TAG_W = 8, UID_W = 4, DEST_W = 4, DEPTH = 4, UNIT_ID = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic tok_valid, tok_ready, tok_inc;
  logic [UID_W-1:0] tok_unit;
  logic [2:0] tok_op;
  logic [TAG_W-1:0] tok_tag;
  logic [DEST_W-1:0] tok_dest;
  logic opa_valid, opb_valid;
  logic [DW-1:0] opa_data, opb_data;
  logic [TAG_W-1:0] opa_tag, opb_tag;
  logic res_valid, res_ready;
  logic [DW-1:0] res_data;
  logic [TAG_W-1:0] res_tag;
  logic [DEST_W-1:0] res_dest;

  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tfu_core #(.DW(DW), .TAG_W(TAG_W), .UID_W(UID_W), .DEST_W(DEST_W),
             .DEPTH(DEPTH), .UNIT_ID(UNIT_ID)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_unit(tok_unit), .tok_op(tok_op),
    .tok_tag(tok_tag), .tok_dest(tok_dest), .tok_inc(tok_inc),
    .opa_valid(opa_valid), .opa_data(opa_data), .opa_tag(opa_tag),
    .opb_valid(opb_valid), .opb_data(opb_data), .opb_tag(opb_tag),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_tag(res_tag), .res_dest(res_dest)
  );

  typedef struct packed {
    logic [2:0]        op;
    logic [DW-1:0]     a;
    logic [DW-1:0]     b;
    logic [TAG_W-1:0]  tag;
    logic              inc;
    logic [DEST_W-1:0] dest;
    logic [DW-1:0]     exp_d;
    logic [TAG_W-1:0]  exp_t;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 32'd5,        32'd7,     8'h03, 1'b0, 4'd1,  32'd12,       8'h03},
    '{3'd1, 32'd10,       32'd3,     8'h09, 1'b1, 4'd2,  32'd7,        8'h0A},
    '{3'd1, 32'd0,        32'd1,     8'h20, 1'b0, 4'd3,  32'hFFFFFFFF, 8'h20},
    '{3'd2, 32'hF0F0,     32'hFF00,  8'h01, 1'b1, 4'd4,  32'hF000,     8'h02},
    '{3'd3, 32'h0F,       32'hF0,    8'h07, 1'b0, 4'd5,  32'hFF,       8'h07},
    '{3'd4, 32'hFF,       32'h0F,    8'h08, 1'b0, 4'd6,  32'hF0,       8'h08},
    '{3'd5, 32'd1,        32'd4,     8'hFF, 1'b1, 4'd7,  32'd16,       8'h00},
    '{3'd6, 32'h1234,     32'h9999,  8'h05, 1'b0, 4'd8,  32'h1234,     8'h05},
    '{3'd7, 32'h77,       32'h88,    8'h40, 1'b1, 4'd9,  32'd0,        8'h41},
    '{3'd0, 32'hFFFFFFFF, 32'd1,     8'hAA, 1'b1, 4'd15, 32'd0,        8'hAB}
  };

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_opnd(input bit port_b, input logic [DW-1:0] d, input logic [TAG_W-1:0] t);
    @(negedge clk);
    if (port_b) begin opb_valid = 1'b1; opb_data = d; opb_tag = t; end
    else        begin opa_valid = 1'b1; opa_data = d; opa_tag = t; end
    @(negedge clk);
    opa_valid = 1'b0;
    opb_valid = 1'b0;
  endtask

  task automatic send_tok(input logic [UID_W-1:0] u, input logic [2:0] op,
                          input logic [TAG_W-1:0] t, input logic [DEST_W-1:0] d, input logic inc);
    @(negedge clk);
    tok_valid = 1'b1; tok_unit = u; tok_op = op; tok_tag = t; tok_dest = d; tok_inc = inc;
    while (!tok_ready) @(negedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic wait_res(input int max, output bit got);
    got = 1'b0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (res_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic expect_res(input string req, input logic [DW-1:0] d,
                            input logic [TAG_W-1:0] t, input logic [DEST_W-1:0] dst);
    bit got;
    wait_res(12, got);
    check(got, req, DW'(got), 1);
    if (got) begin
      check(res_data == d, req, res_data, d);
      check(res_tag == t, req, DW'(res_tag), DW'(t));
      check(res_dest == dst, req, DW'(res_dest), DW'(dst));
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    bit got;
    logic [DW-1:0] hold_d;
    logic [TAG_W-1:0] hold_t;
    rst_n = 1'b0;
    tok_valid = 0; tok_unit = '0; tok_op = '0; tok_tag = '0; tok_dest = '0; tok_inc = 0;
    opa_valid = 0; opa_data = '0; opa_tag = '0;
    opb_valid = 0; opb_data = '0; opb_tag = '0;
    res_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(res_valid == 1'b0, "R1 res_valid", DW'(res_valid), 0);
    check(tok_ready == 1'b1, "R1 tok_ready", DW'(tok_ready), 1);

    // R6 zero-operand op with empty ports: valid at second edge after acceptance
    send_tok(UID_W'(UNIT_ID), 3'd7, 8'h33, 4'd2, 1'b0);
    check(res_valid == 1'b0, "R6 not yet", DW'(res_valid), 0);
    @(negedge clk);
    check(res_valid == 1'b1, "R6 valid", DW'(res_valid), 1);
    check(res_tag == 8'h33 && res_data == '0, "R6 value", DW'(res_tag), 32'h33);

    // R3 R7 R8 table walk
    for (int i = 0; i < NVEC; i++) begin
      send_opnd(1'b0, VEC[i].a, VEC[i].tag);
      send_opnd(1'b1, VEC[i].b, VEC[i].tag);
      send_tok(UID_W'(UNIT_ID), VEC[i].op, VEC[i].tag, VEC[i].dest, VEC[i].inc);
      expect_res("R3/R7/R8 table", VEC[i].exp_d, VEC[i].exp_t, VEC[i].dest);
    end

    // R2 foreign token ignored, operands survive
    send_opnd(1'b0, 32'd100, 8'h50);
    send_opnd(1'b1, 32'd23, 8'h50);
    send_tok(UID_W'(UNIT_ID + 1), 3'd0, 8'h50, 4'd1, 1'b0);
    wait_res(8, got);
    check(!got, "R2 foreign token fired", DW'(got), 0);
    send_tok(UID_W'(UNIT_ID), 3'd0, 8'h50, 4'd3, 1'b0);
    expect_res("R2 operands kept", 32'd123, 8'h50, 4'd3);

    // R4 R5 tag mismatch waits
    send_opnd(1'b0, 32'd3, 8'h60);
    send_opnd(1'b1, 32'd4, 8'h61);
    send_tok(UID_W'(UNIT_ID), 3'd0, 8'h61, 4'd4, 1'b1);
    wait_res(6, got);
    check(!got, "R4 fired on wrong tag", DW'(got), 0);
    send_opnd(1'b0, 32'd30, 8'h61);
    expect_res("R5 matching data fires", 32'd34, 8'h62, 4'd4);

    // R4 pass needs only port A (port B now empty)
    send_opnd(1'b0, 32'hBEEF, 8'h70);
    send_tok(UID_W'(UNIT_ID), 3'd6, 8'h70, 4'd5, 1'b0);
    expect_res("R4 pass with A only", 32'hBEEF, 8'h70, 4'd5);

    // R9 R10 queue full under stalled output, order preserved
    @(negedge clk);
    res_ready = 1'b0;
    for (int k = 0; k < DEPTH + 1; k++)
      send_tok(UID_W'(UNIT_ID), 3'd7, 8'(8'h80 + k), 4'(k), 1'b0);
    @(negedge clk);
    check(tok_ready == 1'b0, "R9 tok_ready when full", DW'(tok_ready), 0);
    check(res_valid && res_tag == 8'h80, "R9 first result", DW'(res_tag), 32'h80);
    hold_d = res_data;
    hold_t = res_tag;
    tok_valid = 1'b1; tok_unit = UID_W'(UNIT_ID); tok_op = 3'd7; tok_tag = 8'h85;
    tok_dest = 4'd0; tok_inc = 1'b0;
    repeat (3) @(negedge clk);
    tok_valid = 1'b0;
    check(res_valid && res_tag == hold_t && res_data == hold_d, "R10 held", DW'(res_tag), DW'(hold_t));
    res_ready = 1'b1;
    for (int k = 1; k < DEPTH + 1; k++)
      expect_res("R9 order", '0, 8'(8'h80 + k), 4'(k));
    wait_res(6, got);
    check(!got, "R9 token offered while full taken", DW'(got), 0);

    done = 1'b1;
    finish_run();
  end
endmodule